// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one byte at a time into an asynchronous serial frame. A line-configuration input selects the number of data bits (five to eight), one or two stop bits, and one of several parity behaviours: none, odd, even, a constant one or a constant zero. A byte is offered with a valid/ready handshake. It is taken only while the transmitter is idle. The block then walks through the frame one bit per pulse of an externally generated bit-period tick.

Alongside the serial line, the block reports whether it is empty. It also reports the position of the bit now on the line, so that the external timing generator can lengthen or shorten individual bits of the frame. A break control pulls the line low in place of frames. A loopback control sends the serial stream to the receive-side output instead of the pin, and the pin then rests at the idle level.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits least-significant first. The count of data bits comes from `cfg_len`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R2: After the data bits and any parity bit come high stop bits: one when `cfg_stop2` is 0, two when it is 1.
- R3: `cfg_par` = 4 adds an odd-parity bit and `cfg_par` = 5 adds an even-parity bit. Either bit is computed over the data bits actually sent and is placed right after the last data bit.
- R4: `cfg_par` = 6 adds a parity bit that is always 1, and `cfg_par` = 7 adds one that is always 0.
- R5: `cfg_par` values 0, 1, 2 and 3 add no parity bit, so the stop bits follow the last data bit directly.
- R6: Coming out of reset, and whenever no frame is in flight (break and loopback off), `tx_pin` is high, `tx_empty` is high and `bit_idx` is 0.
- R7: `in_ready` is low while a frame is being sent. A byte offered during a frame is not taken and does not alter the frame.
- R8: `bit_idx` is 0 during the start bit and rises by one at each bit boundary, up to the last stop bit.
- R9: The line moves to the next bit only on a clock edge where `bit_tick` is high. The tick after the last stop bit ends the frame and raises `tx_empty`. A tick while idle has no effect.
- R10: While `cfg_break` is high (loopback off), `tx_pin` is low, `in_ready` is low and no byte is taken.
- R11: When `cfg_loop` is high, `rx_core` carries the transmitted serial stream and `tx_pin` stays high. When it is low, `rx_core` follows `rx_pin`.
- R12: Data length, stop count and parity are captured when the byte is taken. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 2 | Data-length code (5 + code bits) |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_par | input | 3 | Parity mode code |
| cfg_break | input | 1 | Hold the line low, block new bytes |
| cfg_loop | input | 1 | Route the serial stream to `rx_core`, hold the pin idle |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| bit_tick | input | 1 | One pulse per bit period |
| rx_pin | input | 1 | Serial input from the pad |
| tx_pin | output | 1 | Serial output to the pad |
| rx_core | output | 1 | Serial stream toward the receiver |
| tx_empty | output | 1 | High when no frame is in flight |
| bit_idx | output | 4 | Position of the bit on the line within the frame |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse. They also assume the handshake and configuration inputs are clean synchronous levels, with the break control never raised in the middle of a frame. The bench drives every input on the falling edge and fires each tick for exactly one cycle, with a random gap of idle cycles between ticks. It raises break only while the block is idle. Random stimulus varies the byte, all configuration codes and the loopback setting, and it also rewrites the frame configuration and offers junk bytes while a frame is in flight.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_MAX  = 8;
    localparam int STOP_MAX  = 2;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + STOP_MAX;
    localparam int IDX_W     = $clog2(FRAME_MAX);

    localparam logic [2:0] PAR_ODD  = 3'd4;
    localparam logic [2:0] PAR_EVEN = 3'd5;
    localparam logic [2:0] PAR_ONE  = 3'd6;
    localparam logic [2:0] PAR_ZERO = 3'd7;

    typedef struct packed {
        logic [1:0] len;
        logic       stop2;
        logic [2:0] par;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [IDX_W-1:0]     last;
    } frame_t;

    function automatic int data_count(input logic [1:0] len);
        return 5 + int'(len);
    endfunction

    function automatic logic parity_on(input logic [2:0] par);
        return par[2];
    endfunction

    function automatic logic parity_value(input logic [2:0] par,
                                          input logic [DATA_MAX-1:0] data,
                                          input int n);
        logic ones;
        ones = 1'b0;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < n) ones = ones ^ data[i];
        case (par)
            PAR_ODD:  return ~ones;
            PAR_EVEN: return ones;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  frame_cfg_t          cfg,
    input  logic [DATA_MAX-1:0] data,
    output frame_t              frame
);
    int   n_data;
    logic p_on;

    always_comb begin
        n_data     = data_count(cfg.len);
        p_on       = parity_on(cfg.par);
        frame.bits = '1;
        frame.bits[0] = 1'b0;
        for (int j = 1; j <= DATA_MAX; j++)
            if (j <= n_data) frame.bits[j] = data[j-1];
        if (p_on)
            frame.bits[n_data+1] = parity_value(cfg.par, data, n_data);
        frame.last = IDX_W'(n_data + int'(p_on) + int'(cfg.stop2) + 1);
    end
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_t           frame_in,
    input  logic             tick,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             bit_val
);
    frame_t frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '1;
            busy    <= 1'b0;
            idx     <= '0;
        end else if (start) begin
            frame_q <= frame_in;
            busy    <= 1'b1;
            idx     <= '0;
        end else if (busy && tick) begin
            if (idx == frame_q.last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign bit_val = busy ? frame_q.bits[idx] : 1'b1;

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !tick && !start |=> $stable(idx));

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && tick && idx != frame_q.last |=> idx == $past(idx) + 1'b1);

    // R6
    idle_idx_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> idx == '0);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_stop2,
    input  logic [2:0]       cfg_par,
    input  logic             cfg_break,
    input  logic             cfg_loop,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             bit_tick,
    input  logic             rx_pin,
    output logic             tx_pin,
    output logic             rx_core,
    output logic             tx_empty,
    output logic [IDX_W-1:0] bit_idx
);
    frame_cfg_t cfg;
    frame_t     frame_new;
    logic       busy;
    logic       bit_val;
    logic       accept;
    logic       line;

    assign cfg = '{len: cfg_len, stop2: cfg_stop2, par: cfg_par};

    uart_tx_framer i_framer (
        .cfg   (cfg),
        .data  (in_data),
        .frame (frame_new)
    );

    uart_tx_sequencer i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame_in (frame_new),
        .tick     (bit_tick),
        .busy     (busy),
        .idx      (bit_idx),
        .bit_val  (bit_val)
    );

    assign in_ready = !busy && !cfg_break;
    assign accept   = in_valid && in_ready;
    assign line     = cfg_break ? 1'b0 : bit_val;
    assign tx_pin   = cfg_loop ? 1'b1 : line;
    assign rx_core  = cfg_loop ? line : rx_pin;
    assign tx_empty = !busy;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !cfg_break && !cfg_loop |=>
            !tx_empty && bit_idx == '0 && (cfg_break || cfg_loop || !tx_pin));

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_empty |-> !in_ready);

    // R10
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_break && !cfg_loop |-> !tx_pin);

    // R6
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty && !cfg_break && !cfg_loop |-> tx_pin);

    // R9
    idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty && !in_valid |=> tx_empty);
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_len;
    logic       cfg_stop2;
    logic [2:0] cfg_par;
    logic       cfg_break;
    logic       cfg_loop;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       bit_tick;
    logic       rx_pin;
    logic       tx_pin;
    logic       rx_core;
    logic       tx_empty;
    logic [3:0] bit_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_stop2(cfg_stop2),
        .cfg_par(cfg_par), .cfg_break(cfg_break), .cfg_loop(cfg_loop),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bit_tick(bit_tick), .rx_pin(rx_pin), .tx_pin(tx_pin),
        .rx_core(rx_core), .tx_empty(tx_empty), .bit_idx(bit_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [7:0] d, input logic [1:0] len,
                                   input logic [2:0] par, input int k);
        int  nd;
        int  ones;
        nd = 5 + int'(len);
        ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(d[i]);
        if (k == 0) return 1'b0;
        if (k <= nd) return d[k-1];
        if (par >= 3'd4 && k == nd + 1) begin
            if (par == 3'd4) return (ones % 2) == 0;
            if (par == 3'd5) return (ones % 2) == 1;
            if (par == 3'd6) return 1'b1;
            return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic string tag_of(input logic [1:0] len, input logic [2:0] par,
                                     input int k);
        int nd;
        nd = 5 + int'(len);
        if (k <= nd) return "R1";
        if (k == nd + 1) begin
            if (par == 3'd4 || par == 3'd5) return "R3";
            if (par >= 3'd6) return "R4";
            if (par != 3'd0) return "R5";
        end
        return "R2";
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] len, input bit st,
                        input logic [2:0] par, input bit lp, input bit junk,
                        input bit scramble, input int max_gap);
        int n;
        @(negedge clk);
        cfg_len = len; cfg_stop2 = st; cfg_par = par; cfg_loop = lp;
        rx_pin = 1'($urandom);
        in_data = d; in_valid = 1'b1;
        chk(in_ready == 1'b1, "R7", "ready when idle", int'(in_ready), 1);
        n = 1 + 5 + int'(len) + ((par >= 3'd4) ? 1 : 0) + 1 + int'(st);
        @(posedge clk);
        @(negedge clk);
        in_valid = junk;
        in_data  = ~d;
        if (scramble) begin
            // R12: new frame settings mid-frame must not matter
            cfg_len = 2'($urandom); cfg_stop2 = 1'($urandom); cfg_par = 3'($urandom);
        end
        for (int k = 0; k < n; k++) begin
            bit e;
            int gap;
            e = exp_bit(d, len, par, k);
            if (lp) begin
                chk(rx_core == e, "R11", "looped bit", int'(rx_core), int'(e));
                chk(tx_pin == 1'b1, "R11", "pin idle in loopback", int'(tx_pin), 1);
            end else begin
                chk(tx_pin == e, tag_of(len, par, k), "frame bit", int'(tx_pin), int'(e));
                chk(rx_core == rx_pin, "R11", "rx passthrough", int'(rx_core), int'(rx_pin));
            end
            chk(bit_idx == 4'(k), "R8", "bit index", int'(bit_idx), k);
            chk(tx_empty == 1'b0 && in_ready == 1'b0, "R7", "busy during frame",
                int'(in_ready), 0);
            gap = int'($urandom_range(0, max_gap));
            repeat (gap) @(negedge clk);
            if (gap > 0) begin
                chk(bit_idx == 4'(k), "R9", "index held without tick", int'(bit_idx), k);
                if (!lp)
                    chk(tx_pin == e, "R9", "bit held without tick", int'(tx_pin), int'(e));
            end
            bit_tick = 1'b1;
            if (k == n - 1) in_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            bit_tick = 1'b0;
        end
        chk(tx_empty == 1'b1, "R9", "empty after last stop", int'(tx_empty), 1);
        chk(tx_pin == 1'b1, "R6", "idle high after frame", int'(tx_pin), 1);
        chk(bit_idx == 4'd0, "R6", "index zero when idle", int'(bit_idx), 0);
        cfg_loop = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                done = 1;
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_len = 2'd3; cfg_stop2 = 1'b0; cfg_par = 3'd0;
        cfg_break = 1'b0; cfg_loop = 1'b0; in_data = 8'h00; in_valid = 1'b0;
        bit_tick = 1'b0; rx_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_pin == 1'b1, "R6", "reset line", int'(tx_pin), 1);
        chk(tx_empty == 1'b1, "R6", "reset empty", int'(tx_empty), 1);
        chk(bit_idx == 4'd0, "R6", "reset index", int'(bit_idx), 0);

        // R9: ticks while idle change nothing
        bit_tick = 1'b1;
        repeat (3) @(negedge clk);
        bit_tick = 1'b0;
        chk(tx_empty == 1'b1 && tx_pin == 1'b1, "R9", "idle tick", int'(tx_pin), 1);
        chk(bit_idx == 4'd0, "R9", "idle tick index", int'(bit_idx), 0);

        // directed corners
        send(8'hA5, 2'd3, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1); // R3 odd, 12-bit frame
        send(8'hA5, 2'd3, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 2); // R3 even
        send(8'h1F, 2'd0, 1'b0, 3'd6, 1'b0, 1'b1, 1'b1, 0); // R4 forced one
        send(8'hFF, 2'd1, 1'b1, 3'd7, 1'b0, 1'b0, 1'b1, 1); // R4 forced zero
        send(8'h5A, 2'd2, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1); // R5 code 2
        send(8'h00, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 0); // shortest frame
        send(8'h3C, 2'd3, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 2); // R11 loopback

        // R10: break holds the line low and blocks bytes
        @(negedge clk);
        cfg_break = 1'b1; in_valid = 1'b1; in_data = 8'h77;
        repeat (4) begin
            @(negedge clk);
            chk(tx_pin == 1'b0, "R10", "break line low", int'(tx_pin), 0);
            chk(in_ready == 1'b0, "R10", "break blocks ready", int'(in_ready), 0);
            chk(tx_empty == 1'b1, "R10", "no byte taken in break", int'(tx_empty), 1);
        end
        in_valid = 1'b0;
        cfg_break = 1'b0;
        @(negedge clk);
        chk(tx_pin == 1'b1 && tx_empty == 1'b1, "R10", "line after break",
            int'(tx_pin), 1);

        // random frames
        for (int f = 0; f < 60; f++)
            send(8'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
                 ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        done = 1;
        $finish;
    end
endmodule